// File: doc/BRIEF.md
# Serial DAC Command Controller

This block is the digital front end of a 12-bit voltage-output converter. A host shifts a 16-bit word into it over a three-wire serial port (active-low chip select, serial clock, data in). When chip select returns high, the controller decodes the word. It then acts on a double-buffered pair of code registers: a staging register and the register that drives the converter. It also drives a spare logic output that software controls, and it records the edge mode used by a separate readback block.

The controller also manages power-down. A command or a rising power-down pin puts the output into a high-impedance state. A lockout pin can veto entry and can wake the part on its falling edge. An active-low clear pin forces both registers to a reset code, chosen by a strap pin as zero or midscale. The clear also ends any shutdown. The serial logic runs on the serial clock. Chip select and the slow control pins are brought into the system clock domain through two-flop synchronisers before any command takes effect.

Top module: `sdac_cmd_ctrl`

## Requirements
- R1: A frame is 16 bits sent MSB first while csN is low, sampled on rising sclk. Word bits 15:13 hold the opcode and bits 12:1 hold the 12-bit data, MSB first. Bit 0 is a sub-bit whose value is ignored. The command executes a few system clocks after csN rises.
- R2: A frame with fewer than 16 sclk rising edges has no effect on any output.
- R3: Opcode 001 writes the data to the staging register and leaves dacCode unchanged.
- R4: Opcode 010 copies the staging register to dacCode and ends shutdown.
- R5: Opcode 011 writes the data to both registers (dacCode equals the data) and ends shutdown.
- R6: Opcode 100 drives upoLevel low and opcode 101 drives it high. upoLevel keeps its level through shutdown.
- R7: Opcode 111 sets doutRiseMode to data bit D11 (word bit 12).
- R8: Opcode 110 with pdlPin high enters shutdown: outEnable goes low and dacCode keeps its value. Staging loads still work while in shutdown.
- R9: While pdlPin is low, neither opcode 110 nor a rising edge on pdPin enters shutdown.
- R10: A rising edge on pdPin with pdlPin high enters shutdown. pdPin returning low does not end it. A falling edge on pdlPin ends it.
- R11: While clrN is low, both registers hold the reset code, shutdown ends, upoLevel is low, and serial commands are ignored.
- R12: After rstN, both registers hold the reset code: 0x800 when rstSelMid is high, 0x000 when it is low. upoLevel is low, doutRiseMode is 0 and outEnable is high.
- R13: Opcode 000 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-up reset |
| sclk | input | 1 | Serial clock, data sampled on rising edge |
| csN | input | 1 | Active-low frame select |
| din | input | 1 | Serial data in |
| pdPin | input | 1 | Power-down request, rising edge acts |
| pdlPin | input | 1 | Lockout: low blocks shutdown, falling edge wakes |
| clrN | input | 1 | Active-low clear to reset code |
| rstSelMid | input | 1 | Reset code select: 1 midscale, 0 zero |
| dacCode | output | 12 | Code driven to the converter |
| outEnable | output | 1 | 1 drives the output, 0 high impedance |
| upoLevel | output | 1 | Software-controlled logic output |
| doutRiseMode | output | 1 | Readback edge mode: 1 rising, 0 falling |

## Verification
The bench targets truncated frames. A design that counted edges wrongly would load a 15-bit word shifted off by one. It checks that a staging load during shutdown neither re-enables the output nor disturbs the held code; a design that treated any command as a wake-up would re-enable the output. It checks that releasing the power-down pin leaves the part asleep and that a lockout falling edge wakes it. A level-sensitive design would wake on release or re-enter shutdown at once. It also checks that clear overrides both shutdown and serial loads, and that the sub-bit is ignored. A design that let a serial load through during clear would show the loaded code instead of the reset code.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  parameter int DacW = 12;
  parameter int OpW = 3;
  localparam int WordW = OpW + DacW + 1;
  localparam int OpLsb = DacW + 1;

  typedef enum logic [OpW-1:0] {
    OpNop      = 3'd0,
    OpLoadIn   = 3'd1,
    OpUpdate   = 3'd2,
    OpLoadBoth = 3'd3,
    OpUpoLow   = 3'd4,
    OpUpoHigh  = 3'd5,
    OpSleep    = 3'd6,
    OpOutMode  = 3'd7
  } op_e;

  typedef struct packed {
    logic            clrRegs;
    logic            loadIn;
    logic            copyDac;
    logic            loadBoth;
    logic            upoHigh;
    logic            upoLow;
    logic            modeWr;
    logic [DacW-1:0] data;
  } strobe_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int Width = 4,
  parameter logic [Width-1:0] RstVal = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] asyncIn,
  output logic [Width-1:0] syncOut
);
  for (genvar g = 0; g < Width; g++) begin : gSync
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RstVal[g];
        stage2 <= RstVal[g];
      end else begin
        stage1 <= asyncIn[g];
        stage2 <= stage1;
      end
    end
    assign syncOut[g] = stage2;
  end
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  localparam int CntW = $clog2(WordW + 1)
) (
  input  logic             sclk,
  input  logic             csN,
  input  logic             rstN,
  input  logic             din,
  output logic [WordW-1:0] heldWord,
  output logic             heldOk
);
  logic             frameIdle;
  logic [CntW-1:0]  bitCnt;
  logic [WordW-1:0] shiftReg;

  assign frameIdle = csN | ~rstN;

  // edge counter, cleared whenever no frame is open, saturates at a full word
  always_ff @(posedge sclk or posedge frameIdle) begin
    if (frameIdle) bitCnt <= '0;
    else if (bitCnt != CntW'(WordW)) bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (!csN) shiftReg <= {shiftReg[WordW-2:0], din};
  end

  // the word and its completeness are frozen at the end of the frame
  always_ff @(posedge csN or negedge rstN) begin
    if (!rstN) begin
      heldWord <= '0;
      heldOk   <= 1'b0;
    end else begin
      heldWord <= shiftReg;
      heldOk   <= (bitCnt == CntW'(WordW));
    end
  end
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csS,
  input  logic             pdS,
  input  logic             pdlS,
  input  logic             clrS,
  input  logic [WordW-1:0] frameWord,
  input  logic             frameOk,
  output strobe_t          st,
  output logic             sleeping
);
  logic csPrev, pdPrev, pdlPrev;
  logic csRise, pdRise, pdlFall;
  logic cmdFire, cmdWake, enterReq, wakeReq;
  op_e  opcode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      pdPrev  <= 1'b0;
      pdlPrev <= 1'b0;
    end else begin
      csPrev  <= csS;
      pdPrev  <= pdS;
      pdlPrev <= pdlS;
    end
  end

  assign csRise  = csS & ~csPrev;
  assign pdRise  = pdS & ~pdPrev;
  assign pdlFall = ~pdlS & pdlPrev;
  assign opcode  = op_e'(frameWord[WordW-1 -: OpW]);
  assign cmdFire = csRise & frameOk & clrS;

  always_comb begin
    st          = '0;
    st.data     = frameWord[OpLsb-1 -: DacW];
    st.clrRegs  = ~clrS;
    if (cmdFire) begin
      unique case (opcode)
        OpLoadIn:   st.loadIn   = 1'b1;
        OpUpdate:   st.copyDac  = 1'b1;
        OpLoadBoth: st.loadBoth = 1'b1;
        OpUpoLow:   st.upoLow   = 1'b1;
        OpUpoHigh:  st.upoHigh  = 1'b1;
        OpOutMode:  st.modeWr   = 1'b1;
        default:    ;
      endcase
    end
  end

  assign cmdWake  = cmdFire & (opcode == OpUpdate || opcode == OpLoadBoth);
  assign wakeReq  = ~clrS | pdlFall | cmdWake;
  assign enterReq = pdlS & ((cmdFire & (opcode == OpSleep)) | pdRise);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sleeping <= 1'b0;
    else if (wakeReq) sleeping <= 1'b0;
    else if (enterReq) sleeping <= 1'b1;
  end

  // R9
  pdl_blocks_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pdlS && !sleeping) |=> !sleeping);

  // R11
  clr_wakes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrS |=> !sleeping);

  // R10
  pd_release_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pdS) && sleeping && pdlS && clrS && !csRise) |=> sleeping);
endmodule

// File: rtl/sdac_datapath.sv
module sdac_datapath
  import sdac_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            rstSelMid,
  input  strobe_t         st,
  output logic [DacW-1:0] dacReg,
  output logic            upoReg,
  output logic            modeReg
);
  logic [DacW-1:0] stageReg;
  logic [DacW-1:0] resetCode;

  assign resetCode = rstSelMid ? DacW'(1) << (DacW - 1) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageReg <= resetCode;
      dacReg   <= resetCode;
    end else if (st.clrRegs) begin
      stageReg <= resetCode;
      dacReg   <= resetCode;
    end else begin
      if (st.loadIn || st.loadBoth) stageReg <= st.data;
      if (st.loadBoth) dacReg <= st.data;
      else if (st.copyDac) dacReg <= stageReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upoReg  <= 1'b0;
      modeReg <= 1'b0;
    end else begin
      if (st.clrRegs || st.upoLow) upoReg <= 1'b0;
      else if (st.upoHigh) upoReg <= 1'b1;
      if (st.modeWr) modeReg <= st.data[DacW-1];
    end
  end

  // R3
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(st.copyDac || st.loadBoth || st.clrRegs) |=> $stable(dacReg));

  // R11
  clr_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrRegs && $stable(rstSelMid)) |=> (dacReg == resetCode && stageReg == resetCode && !upoReg));

  // R5
  load_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadBoth && !st.clrRegs) |=> (dacReg == $past(st.data)));
endmodule

// File: rtl/sdac_cmd_ctrl.sv
module sdac_cmd_ctrl
  import sdac_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclk,
  input  logic            csN,
  input  logic            din,
  input  logic            pdPin,
  input  logic            pdlPin,
  input  logic            clrN,
  input  logic            rstSelMid,
  output logic [DacW-1:0] dacCode,
  output logic            outEnable,
  output logic            upoLevel,
  output logic            doutRiseMode
);
  logic [WordW-1:0] frameWord;
  logic             frameOk;
  logic [3:0]       syncVec;
  strobe_t          st;
  logic             sleeping;

  sdac_shifter shifter_i (
    .sclk     (sclk),
    .csN      (csN),
    .rstN     (rstN),
    .din      (din),
    .heldWord (frameWord),
    .heldOk   (frameOk)
  );

  // order: {clr, pdl, pd, cs}
  sdac_sync #(.Width(4), .RstVal(4'b1001)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({clrN, pdlPin, pdPin, csN}),
    .syncOut (syncVec)
  );

  sdac_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .csS       (syncVec[0]),
    .pdS       (syncVec[1]),
    .pdlS      (syncVec[2]),
    .clrS      (syncVec[3]),
    .frameWord (frameWord),
    .frameOk   (frameOk),
    .st        (st),
    .sleeping  (sleeping)
  );

  sdac_datapath datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .rstSelMid (rstSelMid),
    .st        (st),
    .dacReg    (dacCode),
    .upoReg    (upoLevel),
    .modeReg   (doutRiseMode)
  );

  assign outEnable = ~sleeping;
endmodule

// File: tb/sdac_cmd_ctrl_tb.sv
module sdac_cmd_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic din = 1'b0;
  logic pdPin = 1'b0;
  logic pdlPin = 1'b1;
  logic clrN = 1'b1;
  logic rstSelMid = 1'b1;
  logic [11:0] dacCode;
  logic outEnable, upoLevel, doutRiseMode;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  logic [11:0] expStage, expDac;
  logic expUpo, expMode, expOn;

  always #5 clk = ~clk;

  sdac_cmd_ctrl dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .pdPin(pdPin), .pdlPin(pdlPin), .clrN(clrN), .rstSelMid(rstSelMid),
    .dacCode(dacCode), .outEnable(outEnable), .upoLevel(upoLevel),
    .doutRiseMode(doutRiseMode)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check({req, " dacCode"}, int'(dacCode), int'(expDac));
    check({req, " outEnable"}, int'(outEnable), int'(expOn));
    check({req, " upoLevel"}, int'(upoLevel), int'(expUpo));
    check({req, " doutRiseMode"}, int'(doutRiseMode), int'(expMode));
  endtask

  function automatic logic [15:0] mkWord(input logic [2:0] op, input logic [11:0] data);
    return {op, data, 1'b0};
  endfunction

  task automatic settle();
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendBits(input logic [15:0] word, input int nBits);
    @(negedge clk);
    csN = 1'b0;
    #30;
    for (int i = 0; i < nBits; i++) begin
      din = word[15-i];
      #20 sclk = 1'b1;
      #20 sclk = 1'b0;
    end
    #30 csN = 1'b1;
    settle();
  endtask

  // expected effect of one frame, given current pin levels
  task automatic modelFrame(input logic [15:0] word, input int nBits);
    logic [2:0] op;
    logic [11:0] data;
    op = word[15:13];
    data = word[12:1];
    if (nBits < 16 || !clrN) return;
    case (op)
      3'd1: expStage = data;
      3'd2: begin expDac = expStage; expOn = 1'b1; end
      3'd3: begin expStage = data; expDac = data; expOn = 1'b1; end
      3'd4: expUpo = 1'b0;
      3'd5: expUpo = 1'b1;
      3'd6: if (pdlPin) expOn = 1'b0;
      3'd7: expMode = data[11];
      default: ;
    endcase
  endtask

  task automatic doFrame(input logic [15:0] word, input int nBits, input string req);
    sendBits(word, nBits);
    modelFrame(word, nBits);
    checkAll(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    settle();
    expStage = 12'h800; expDac = 12'h800; expUpo = 0; expMode = 0; expOn = 1;
    checkAll("R12 reset midscale");

    doFrame(mkWord(3'd1, 12'h123), 16, "R3 load staging only");
    doFrame(mkWord(3'd2, 12'h000), 16, "R4 copy staging");
    doFrame(mkWord(3'd3, 12'hABC) | 16'h0001, 16, "R5 R1 load both, sub-bit set");
    doFrame(mkWord(3'd3, 12'h111), 15, "R2 short frame ignored");
    doFrame(mkWord(3'd1, 12'h2F0), 3, "R2 very short frame ignored");
    doFrame(mkWord(3'd0, 12'hFFF), 16, "R13 no-op");
    doFrame(mkWord(3'd5, 12'h000), 16, "R6 upo high");
    doFrame(mkWord(3'd7, 12'h800), 16, "R7 rising mode");
    doFrame(mkWord(3'd7, 12'h7FF), 16, "R7 falling mode");

    for (int k = 0; k < 40; k++) begin
      logic [2:0] op;
      logic [11:0] data;
      int nb;
      op = 3'($urandom % 8);
      data = 12'($urandom);
      nb = ($urandom % 6 == 0) ? int'($urandom % 16) : 16;
      doFrame(mkWord(op, data), nb, "R1 random frame");
    end

    // make the state known again
    doFrame(mkWord(3'd3, 12'h3C3), 16, "R5 resync");
    doFrame(mkWord(3'd5, 12'h000), 16, "R6 upo high again");

    doFrame(mkWord(3'd6, 12'h000), 16, "R8 software shutdown");
    doFrame(mkWord(3'd1, 12'h055), 16, "R8 staging load while asleep");
    check("R6 upo held in shutdown", int'(upoLevel), 1);
    doFrame(mkWord(3'd2, 12'h000), 16, "R4 update wakes");
    check("R4 woke with staged code", int'(dacCode), 12'h055);

    pdlPin = 1'b0; settle();
    doFrame(mkWord(3'd6, 12'h000), 16, "R9 command blocked by lockout");
    pdPin = 1'b1; settle();
    checkAll("R9 pin blocked by lockout");
    pdPin = 1'b0; settle();
    pdlPin = 1'b1; settle();
    checkAll("R9 lockout released, still awake");

    pdPin = 1'b1; settle();
    expOn = 1'b0;
    checkAll("R10 pin rise enters shutdown");
    pdPin = 1'b0; settle();
    checkAll("R10 pin release keeps shutdown");
    pdlPin = 1'b0; settle();
    expOn = 1'b1;
    checkAll("R10 lockout fall wakes");
    pdlPin = 1'b1; settle();

    doFrame(mkWord(3'd6, 12'h000), 16, "R11 sleep before clear");
    rstSelMid = 1'b0;
    clrN = 1'b0; settle();
    expStage = 12'h000; expDac = 12'h000; expUpo = 1'b0; expOn = 1'b1;
    checkAll("R11 clear wakes and resets");
    doFrame(mkWord(3'd3, 12'h777), 16, "R11 load ignored during clear");
    clrN = 1'b1; settle();
    doFrame(mkWord(3'd2, 12'h000), 16, "R11 staging was cleared");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule